// File: doc/BRIEF.md
# Banked Private Countdown Timer

This block holds a set of identical 32-bit down-counting timers, one per core, behind a single shared register window. The `cpu_sel` input picks which copy a request reaches. Each copy has a reload value, a live counter, a control word and a sticky expiry flag. Its counter steps down once every (prescale + 1) pulses of the `tick` enable. When a step finds the counter already at zero, the timer expires. Expiry sets the flag, and then the counter either reloads and keeps going or halts at zero. Each copy drives a level interrupt that is the flag gated by an enable bit.

Software starts, stops and re-arms the timer through register writes. Several corner rules apply when zero is written while the prescale is zero: writing zero to the reload value, writing zero to the counter, or enabling with a zero count. Under these rules the timer refuses to run, or it substitutes the reload value. Reads go through one register stage, so read data appears on the cycle after the request.

Top module: `private_timer_bank`

## Requirements
- R1: A synchronous reset clears reload value, counter, control word and expiry flag of every copy, stops counting, drives `irq` low and `rsp_rdata` to zero.
- R2: Word registers are selected by byte offset: 0x0 reload value, 0x4 counter (live value), 0x8 control, 0xC expiry flag (bit 0). Control bit 0 is enable, bit 1 is auto-reload (0 is one-shot), bit 2 is interrupt enable, and bits 15:8 are the prescale. All other control bits and flag bits 31:1 read as zero. Read data is valid one cycle after the read request.
- R3: Any other offset in the window, including one that is not word aligned, reads as zero, and writes to it change nothing.
- R4: While running, the counter moves once every (prescale + 1) tick pulses, counted from the last write to the reload, counter or control register. Without tick pulses it holds.
- R5: A step that finds the counter at zero sets the flag. In auto-reload mode the counter takes the reload value and continues. In one-shot mode the counter stays at zero and stops.
- R6: `irq[i]` is high exactly while copy i has its flag set and its interrupt-enable bit set.
- R7: Writing the flag register clears the flag where data bit 0 is 1 and leaves it where bit 0 is 0. An expiry in the same cycle as a clearing write wins.
- R8: Writing the reload value also loads the counter. If enabled with prescale 0 and the value is zero, the timer stops. Otherwise an enabled timer runs.
- R9: Writing the counter while enabled with prescale 0 and a zero value works as follows. In auto-reload mode the counter takes the reload value and runs if that is nonzero. In one-shot mode the timer stops. A nonzero value, or a nonzero prescale, runs.
- R10: A control write that changes enable or mode stops the timer. A write with enable set starts it only if the prescale or the count is nonzero. If auto-reload is set, the prescale is 0 and the count is 0, the count is first replaced by the reload value.
- R11: In auto-reload mode with prescale 0 and a zero reload value, the timer stops at expiry.
- R12: Each copy is reached only when `cpu_sel` equals its index, and each copy drives its own `irq` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base count pulse, one clock wide |
| cpu_sel | input | SEL_W | Index of the timer copy addressed |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| irq | output | N_CORES | Per-copy level interrupt |

## Verification
The countdown is tried with a table of prescale, reload value, mode and tick counts. The table covers runs that stop short of expiry, runs that land exactly on the reload cycle, and runs that wrap several times. It also covers one-shot runs that go past expiry. Comparing these runs separates an off-by-one period, a missing reload and a one-shot that keeps counting. Directed cases cover the zero-value rules on each writable register and the flag clear colliding with an expiry. They also check that two copies written through the same window stay separate.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DATA_W  = 32;
  localparam int PRESC_W = 8;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               irq_en;
    logic               reload;
    logic               enable;
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_FF07;

  function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
    return {16'h0, c.presc, 5'h0, c.irq_en, c.reload, c.enable};
  endfunction

  function automatic ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.presc  = w[15:8];
    c.irq_en = w[2];
    c.reload = w[1];
    c.enable = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               step
);
  logic [PRESC_W-1:0] pcnt;
  logic               wrap;

  assign wrap = (pcnt == presc);
  assign step = run & tick & wrap;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pcnt <= '0;
    else if (tick)              pcnt <= wrap ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count_q,
  output ctrl_t             ctrl_q,
  output logic              stat_q,
  output logic              irq
);
  logic              running, step, restart, presc0, expire, same_mode;
  ctrl_t             new_ctrl;
  logic [DATA_W-1:0] cnt_wr, cnt_en;

  assign restart = wr_en && (wr_sel != REG_STAT);
  assign presc0  = (ctrl_q.presc == '0);
  assign expire  = step && (count_q == '0);
  assign irq     = stat_q & ctrl_q.irq_en;

  ptmr_prescale #(.PRESC_W(PRESC_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .run    (running),
    .restart(restart),
    .presc  (ctrl_q.presc),
    .step   (step)
  );

  always_comb begin
    new_ctrl  = word_to_ctrl(wr_data);
    same_mode = (new_ctrl.enable == ctrl_q.enable) && (new_ctrl.reload == ctrl_q.reload);
    cnt_wr    = wr_data;
    if (ctrl_q.enable && ctrl_q.reload && presc0 && wr_data == '0) cnt_wr = load_q;
    cnt_en    = count_q;
    if (new_ctrl.reload && new_ctrl.presc == '0 && count_q == '0) cnt_en = load_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      stat_q  <= 1'b0;
      running <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~(wr_en && wr_sel == REG_STAT && wr_data[0])) | expire;
      if (step) begin
        if (count_q != '0) begin
          count_q <= count_q - 1'b1;
        end else if (ctrl_q.reload) begin
          count_q <= load_q;
          if (load_q == '0 && presc0) running <= 1'b0;
        end else begin
          running <= 1'b0;
        end
      end
      if (wr_en) begin
        unique case (wr_sel)
          REG_LOAD: begin
            load_q  <= wr_data;
            count_q <= wr_data;
            if (ctrl_q.enable) running <= !presc0 || (wr_data != '0);
          end
          REG_COUNT: begin
            count_q <= cnt_wr;
            if (ctrl_q.enable) running <= !presc0 || (cnt_wr != '0);
          end
          REG_CTRL: begin
            ctrl_q  <= new_ctrl;
            if (new_ctrl.enable) count_q <= cnt_en;
            running <= (same_mode && running) ||
                       (new_ctrl.enable && (new_ctrl.presc != '0 || cnt_en != '0));
          end
          REG_STAT: begin
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/private_timer_bank.sv
module private_timer_bank
  import ptmr_pkg::*;
#(
  parameter  int N_CORES = 2,
  parameter  int ADDR_W  = 5,
  localparam int SEL_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [SEL_W-1:0]   cpu_sel,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [N_CORES-1:0] irq
);
  logic                           addr_ok, sel_ok;
  reg_sel_e                       reg_sel;
  logic [N_CORES-1:0][DATA_W-1:0] load_all, count_all;
  ctrl_t                          ctrl_all [N_CORES];
  logic [N_CORES-1:0]             stat_all;
  logic [DATA_W-1:0]              rd_word;

  assign addr_ok = (req_addr[1:0] == 2'b00) && (req_addr[ADDR_W-1:4] == '0);
  assign sel_ok  = ({1'b0, cpu_sel} < (SEL_W + 1)'(N_CORES));
  assign reg_sel = reg_sel_e'(req_addr[3:2]);

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    logic wr_g;
    assign wr_g = req_valid && req_write && addr_ok && sel_ok && (cpu_sel == SEL_W'(g));
    ptmr_core u_core (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .wr_en  (wr_g),
      .wr_sel (reg_sel),
      .wr_data(req_wdata),
      .load_q (load_all[g]),
      .count_q(count_all[g]),
      .ctrl_q (ctrl_all[g]),
      .stat_q (stat_all[g]),
      .irq    (irq[g])
    );
  end

  always_comb begin
    rd_word = '0;
    if (addr_ok && sel_ok) begin
      for (int i = 0; i < N_CORES; i++) begin
        if (cpu_sel == SEL_W'(i)) begin
          unique case (reg_sel)
            REG_LOAD:  rd_word = load_all[i];
            REG_COUNT: rd_word = count_all[i];
            REG_CTRL:  rd_word = ctrl_to_word(ctrl_all[i]);
            REG_STAT:  rd_word = {{(DATA_W-1){1'b0}}, stat_all[i]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          rsp_rdata <= '0;
    else if (req_valid && !req_write) rsp_rdata <= rd_word;
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int ADDR_W  = 5
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           tick,
  input logic                           req_valid,
  input logic                           req_write,
  input logic [ADDR_W-1:0]              req_addr,
  input logic [DATA_W-1:0]              rsp_rdata,
  input logic [N_CORES-1:0]             irq,
  input logic [N_CORES-1:0][DATA_W-1:0] count_all
);
  logic rd, wr, bad;
  assign rd  = req_valid && !req_write;
  assign wr  = req_valid && req_write;
  assign bad = (req_addr[1:0] != 2'b00) || (req_addr[ADDR_W-1:4] != '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq == '0 && rsp_rdata == '0));

  // R3
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bad) |=> (rsp_rdata == '0));

  // R2
  ctrl_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !bad && req_addr[3:2] == 2'd2) |=> ((rsp_rdata & ~CTRL_MASK) == '0));

  // R2
  flag_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !bad && req_addr[3:2] == 2'd3) |=> (rsp_rdata[DATA_W-1:1] == '0));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(count_all));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(irq));
endmodule

bind private_timer_bank ptmr_chk #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_rdata(rsp_rdata),
  .irq      (irq),
  .count_all(count_all)
);

// File: tb/test_private_timer_bank.sv
`timescale 1ns/1ps
module test_private_timer_bank;
  localparam int N_CORES = 2;
  localparam int ADDR_W  = 5;
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08, A_ST = 5'h0C;
  localparam logic [31:0] EN = 32'h1, AUTO = 32'h2, IE = 32'h4;

  // vector table: prescale, reload value, auto, ticks, expected count, expected flag
  localparam int VN = 12;
  localparam int VP [VN] = '{0, 0, 0, 0, 0, 3, 3, 1, 1, 2, 0, 7};
  localparam int VL [VN] = '{5, 5, 5, 5, 5, 4, 4, 2, 2, 0, 1, 100};
  localparam int VA [VN] = '{1, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 0};
  localparam int VT [VN] = '{3, 6, 8, 6, 20, 8, 21, 5, 6, 9, 2, 40};
  localparam int VC [VN] = '{2, 5, 3, 0, 0, 2, 4, 0, 0, 0, 1, 95};
  localparam int VS [VN] = '{0, 1, 1, 1, 1, 0, 1, 0, 1, 1, 1, 0};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               tick = 1'b0;
  logic [0:0]         cpu_sel = '0;
  logic               req_valid = 1'b0;
  logic               req_write = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [31:0]        req_wdata = '0;
  logic [31:0]        rsp_rdata;
  logic [N_CORES-1:0] irq;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic [31:0] v;

  always #4 clk = ~clk;

  private_timer_bank #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) i_private_timer_bank (
    .clk(clk), .rst(rst), .tick(tick), .cpu_sel(cpu_sel),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [4:0] a, input logic [31:0] d);
    cpu_sel = sel; req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [4:0] a, output logic [31:0] d);
    cpu_sel = sel; req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic arm(input logic sel, input logic [31:0] load, input logic [31:0] ctrl);
    wr(sel, A_CTRL, 32'h0);
    wr(sel, A_ST, 32'h1);
    wr(sel, A_LOAD, load);
    wr(sel, A_CTRL, ctrl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd(0, A_LOAD, v); chk("R1 load", v, 0);
    rd(0, A_CNT, v);  chk("R1 count", v, 0);
    rd(1, A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(1, A_ST, v);   chk("R1 flag", v, 0);

    // R2 control readback masks unused bits
    wr(0, A_CTRL, 32'hABCD_5A04);
    rd(0, A_CTRL, v); chk("R2 ctrl readback", v, 32'h0000_5A04);
    wr(0, A_CTRL, 32'h0);

    // R3 holes in the window
    wr(0, A_LOAD, 32'h77);
    wr(0, 5'h10, 32'h1234);
    wr(0, 5'h01, 32'h99);
    rd(0, 5'h10, v);   chk("R3 hole read", v, 0);
    rd(0, 5'h06, v);   chk("R3 misaligned read", v, 0);
    rd(0, A_LOAD, v);  chk("R3 load untouched", v, 32'h77);

    // R4 R5 table walk
    for (int k = 0; k < VN; k++) begin
      arm(0, VL[k], EN | (VA[k] != 0 ? AUTO : 32'h0) | (32'(VP[k]) << 8));
      run_ticks(VT[k]);
      rd(0, A_CNT, v); chk($sformatf("R5 vec%0d count", k), v, VC[k]);
      rd(0, A_ST, v);  chk($sformatf("R5 vec%0d flag", k), v, VS[k]);
    end

    // R4 prescale spacing
    arm(0, 4, EN | AUTO | (32'd3 << 8));
    run_ticks(3);
    rd(0, A_CNT, v); chk("R4 before divide", v, 4);
    run_ticks(1);
    rd(0, A_CNT, v); chk("R4 first step", v, 3);

    // R6 R7 interrupt gating and clear
    arm(0, 1, EN | AUTO);
    run_ticks(2);
    chk("R6 masked irq", 32'(irq[0]), 0);
    wr(0, A_CTRL, EN | AUTO | IE);
    chk("R6 irq raised", 32'(irq[0]), 1);
    wr(0, A_CTRL, EN | AUTO);
    wr(0, A_ST, 32'h0);
    wr(0, A_CTRL, EN | AUTO | IE);
    chk("R7 zero write keeps", 32'(irq[0]), 1);
    wr(0, A_CTRL, 32'h0);
    wr(0, A_ST, 32'h1);
    chk("R7 one write clears irq", 32'(irq[0]), 0);
    rd(0, A_ST, v); chk("R7 flag cleared", v, 0);

    // R8 zero reload write stops
    arm(0, 5, EN | AUTO);
    run_ticks(2);
    wr(0, A_LOAD, 32'h0);
    run_ticks(3);
    rd(0, A_CNT, v); chk("R8 count zero", v, 0);
    rd(0, A_ST, v);  chk("R8 no expiry", v, 0);

    // R9 counter write rules
    arm(0, 7, EN | AUTO);
    wr(0, A_CNT, 32'h0);
    rd(0, A_CNT, v); chk("R9 zero replaced", v, 7);
    run_ticks(2);
    rd(0, A_CNT, v); chk("R9 keeps running", v, 5);
    arm(0, 7, EN);
    wr(0, A_CNT, 32'h0);
    run_ticks(4);
    rd(0, A_ST, v);  chk("R9 one-shot zero stops", v, 0);
    wr(0, A_CNT, 32'h3);
    run_ticks(2);
    rd(0, A_CNT, v); chk("R9 nonzero runs", v, 1);

    // R10 control write rules
    arm(0, 9, EN | AUTO);
    run_ticks(2);
    wr(0, A_CTRL, 32'h0);
    run_ticks(3);
    rd(0, A_CNT, v); chk("R10 disable stops", v, 7);
    arm(0, 0, EN);
    run_ticks(3);
    rd(0, A_ST, v);  chk("R10 zero count no start", v, 0);
    arm(0, 0, EN | (32'd1 << 8));
    run_ticks(2);
    rd(0, A_ST, v);  chk("R10 prescale starts", v, 1);

    // R11 zero reload stops at expiry
    wr(0, A_CTRL, 32'h0);
    wr(0, A_ST, 32'h1);
    wr(0, A_LOAD, 32'h0);
    wr(0, A_CNT, 32'h2);
    wr(0, A_CTRL, EN | AUTO);
    run_ticks(3);
    rd(0, A_ST, v);  chk("R11 expired", v, 1);
    wr(0, A_ST, 32'h1);
    run_ticks(4);
    rd(0, A_ST, v);  chk("R11 stopped", v, 0);
    rd(0, A_CNT, v); chk("R11 count", v, 0);

    // R12 banking
    wr(1, A_LOAD, 32'h55);
    wr(0, A_LOAD, 32'h66);
    rd(1, A_LOAD, v); chk("R12 copy1 load", v, 32'h55);
    rd(0, A_LOAD, v); chk("R12 copy0 load", v, 32'h66);
    arm(1, 1, EN | AUTO | IE);
    run_ticks(2);
    chk("R12 irq split", 32'(irq), 32'h2);

    // R7 expiry beats a clearing write in the same cycle
    arm(1, 1, EN | AUTO);
    run_ticks(1);
    tick = 1'b1;
    wr(1, A_ST, 32'h1);
    tick = 1'b0;
    rd(1, A_ST, v); chk("R7 set wins", v, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule